// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit gathers single-cycle event pulses from a serial-bus subsystem (two data-buffer conditions, slave address match, STOP and repeated START detection, two slave write-then-STOP detections, and master byte completion) into a bank of sticky flag bits.

A separate enable register selects which flags may request service. The unit drives one registered, active-low interrupt line to a microcontroller core. That line is low whenever at least one flag is set together with its enable bit.

Software can clear six of the flags by writing zeros to the flag register. The two buffer flags clear only as a side effect of the data path: the transmit-buffer flag clears on a write to the transmit data buffer, and the receive-buffer flag clears on a read of the receive data buffer. A read port returns the current flag and enable values.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous reset, all flags read 0, all enables read 0, and `irq_n_o` is 1.
- R2: An event pulse on `evt_i[i]` makes flag i read 1 from the next clock onward. This happens whatever the value of enable bit i.
- R3: `irq_n_o` is 0 exactly when, one clock earlier, some flag bit and its matching enable bit were both 1. Otherwise it is 1.
- R4: A flag-register write (`flag_we`=1) clears each flag in bits 5..0 whose write-data bit is 0. It leaves unchanged each flag in bits 5..0 whose write-data bit is 1.
- R5: A flag-register write has no effect on flag bits 7 and 6, whatever the write data.
- R6: A transmit-buffer write strobe (`txbuf_wr_i`) clears flag bit 7 and no other flag.
- R7: A receive-buffer read strobe (`rxbuf_rd_i`) clears flag bit 6 and no other flag.
- R8: When an event pulse and any clear for the same flag arrive in the same cycle, the flag reads 1 afterwards.
- R9: An enable write (`en_we`=1) loads all eight enable bits from `en_wdata`. Without a write, the enables hold their value. Enable writes never change the flags.
- R10: The bit map is the same in the flag, enable and event vectors: 7 transmit buffer needs data, 6 receive buffer has a byte, 5 slave address B match, 4 STOP, 3 repeated START, 2 slave A1 write-STOP, 1 slave A2 write-STOP, 0 master byte done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 8 | Single-cycle event pulses, one per source |
| flag_we | input | 1 | Flag-register write strobe |
| flag_wdata | input | 8 | Flag write data; 0 clears bits 5..0 |
| en_we | input | 1 | Enable-register write strobe |
| en_wdata | input | 8 | Enable write data |
| txbuf_wr_i | input | 1 | Transmit data buffer written |
| rxbuf_rd_i | input | 1 | Receive data buffer read |
| flags_o | output | 8 | Current flag values |
| en_o | output | 8 | Current enable values |
| irq_n_o | output | 1 | Registered active-low interrupt request |

## Verification
All 256 event patterns are raised with the enables at zero. This shows that setting a flag does not depend on enables and that the line stays high. Each pattern is then paired with a different enable mask to separate an AND-then-OR reduction from any wrong pairing of bits.

Every flag pattern also meets a flag write with a different data word, which exposes inverted clear polarity and leakage into bits 7 and 6. The two buffer strobes, which must touch only their own bits, are exercised separately.

A cycle that asserts every event and every clear together checks that a set wins over a clear. A lone enable write after that checks that enables cannot disturb the flags.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int N_SRC = 8;
  // bit positions shared by event, flag and enable vectors
  localparam int SRC_TXB   = 7;
  localparam int SRC_RXB   = 6;
  localparam int SRC_ADRB  = 5;
  localparam int SRC_STOP  = 4;
  localparam int SRC_RSTRT = 3;
  localparam int SRC_A1WS  = 2;
  localparam int SRC_A2WS  = 1;
  localparam int SRC_MBYTE = 0;

  function automatic logic [N_SRC-1:0] w2c_mask();
    logic [N_SRC-1:0] m;
    m = '1;
    m[SRC_TXB] = 1'b0;
    m[SRC_RXB] = 1'b0;
    return m;
  endfunction
endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell #(
  parameter bit CLEAR_BY_STROBE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_clr_i,
  input  logic strobe_clr_i,
  output logic q_o
);
  logic clr;
  assign clr = CLEAR_BY_STROBE ? strobe_clr_i : wr_clr_i;

  always_ff @(posedge clk) begin
    if (rst)        q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;   // set beats clear
    else if (clr)   q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         flag_we,
  input  logic [N-1:0] flag_wdata,
  input  logic         txbuf_wr_i,
  input  logic         rxbuf_rd_i,
  output logic [N-1:0] flags_o
);
  logic [N-1:0] wr_clr;
  assign wr_clr = {N{flag_we}} & ~flag_wdata;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i == SRC_TXB) begin : g_tx
      irq_flag_cell #(.CLEAR_BY_STROBE(1'b1)) u_cell (
        .clk(clk), .rst(rst), .set_i(evt_i[i]), .wr_clr_i(wr_clr[i]),
        .strobe_clr_i(txbuf_wr_i), .q_o(flags_o[i]));
    end else if (i == SRC_RXB) begin : g_rx
      irq_flag_cell #(.CLEAR_BY_STROBE(1'b1)) u_cell (
        .clk(clk), .rst(rst), .set_i(evt_i[i]), .wr_clr_i(wr_clr[i]),
        .strobe_clr_i(rxbuf_rd_i), .q_o(flags_o[i]));
    end else begin : g_w2c
      irq_flag_cell #(.CLEAR_BY_STROBE(1'b0)) u_cell (
        .clk(clk), .rst(rst), .set_i(evt_i[i]), .wr_clr_i(wr_clr[i]),
        .strobe_clr_i(1'b0), .q_o(flags_o[i]));
    end
  end
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (rst)        en_o <= '0;
    else if (en_we) en_o <= en_wdata;
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flags_i,
  input  logic [N-1:0] en_i,
  output logic         irq_n_o
);
  logic any_req;
  assign any_req = |(flags_i & en_i);

  always_ff @(posedge clk) begin
    if (rst) irq_n_o <= 1'b1;
    else     irq_n_o <= ~any_req;
  end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
  import irq_pkg::*;
#(
  parameter int N = N_SRC
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] evt_i,
  input  logic         flag_we,
  input  logic [N-1:0] flag_wdata,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         txbuf_wr_i,
  input  logic         rxbuf_rd_i,
  output logic [N-1:0] flags_o,
  output logic [N-1:0] en_o,
  output logic         irq_n_o
);
  irq_flag_bank #(.N(N)) u_flags (
    .clk(clk), .rst(rst), .evt_i(evt_i), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .txbuf_wr_i(txbuf_wr_i),
    .rxbuf_rd_i(rxbuf_rd_i), .flags_o(flags_o));

  irq_en_reg #(.N(N)) u_en (
    .clk(clk), .rst(rst), .en_we(en_we), .en_wdata(en_wdata), .en_o(en_o));

  irq_line_drv #(.N(N)) u_line (
    .clk(clk), .rst(rst), .flags_i(flags_o), .en_i(en_o), .irq_n_o(irq_n_o));
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk
  import irq_pkg::*;
#(
  parameter int N = N_SRC
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] evt_i,
  input logic         flag_we,
  input logic [N-1:0] flag_wdata,
  input logic         en_we,
  input logic [N-1:0] en_wdata,
  input logic         txbuf_wr_i,
  input logic         rxbuf_rd_i,
  input logic [N-1:0] flags_o,
  input logic [N-1:0] en_o,
  input logic         irq_n_o
);
  localparam logic [N-1:0] W2C = w2c_mask();
  localparam logic [N-1:0] BUF = ~W2C;

  // R2 and R8: every pulsed bit reads set next cycle
  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & $past(evt_i)) == $past(evt_i)));

  // no flag rises without an event
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(evt_i)) == '0));

  p_line_level_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_n_o == !(|($past(flags_o) & $past(en_o)))));

  p_write_one_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    flag_we |=> ((flags_o & $past(flags_o & flag_wdata & W2C))
                 == $past(flags_o & flag_wdata & W2C)));

  p_buf_bits_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!txbuf_wr_i && !rxbuf_rd_i) |=> ((flags_o & $past(flags_o & BUF))
                                       == $past(flags_o & BUF)));

  p_tx_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (txbuf_wr_i && !evt_i[SRC_TXB]) |=> !flags_o[SRC_TXB]);

  p_rx_clears_r7: assert property (@(posedge clk) disable iff (rst)
    (rxbuf_rd_i && !evt_i[SRC_RXB]) |=> !flags_o[SRC_RXB]);

  p_en_load_r9: assert property (@(posedge clk) disable iff (rst)
    en_we |=> (en_o == $past(en_wdata)));

  p_en_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !en_we |=> $stable(en_o));
endmodule

bind irq_flag_unit irq_flag_unit_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .flag_we(flag_we),
  .flag_wdata(flag_wdata), .en_we(en_we), .en_wdata(en_wdata),
  .txbuf_wr_i(txbuf_wr_i), .rxbuf_rd_i(rxbuf_rd_i),
  .flags_o(flags_o), .en_o(en_o), .irq_n_o(irq_n_o));

// File: tb/irq_flag_unit_test.sv
`timescale 1ns/1ps
module irq_flag_unit_test;
  localparam int N = 8;
  localparam logic [N-1:0] W2C = 8'h3F; // R4: bits 5..0 write-zero-to-clear

  logic         clk = 1'b0;
  logic         rst;
  logic [N-1:0] evt_i, flag_wdata, en_wdata;
  logic         flag_we, en_we, txbuf_wr_i, rxbuf_rd_i;
  logic [N-1:0] flags_o, en_o;
  logic         irq_n_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  logic [N-1:0] mf, me;
  logic         mirq;

  always #5 clk = ~clk;

  irq_flag_unit #(.N(N)) uut (
    .clk(clk), .rst(rst), .evt_i(evt_i), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .en_we(en_we), .en_wdata(en_wdata),
    .txbuf_wr_i(txbuf_wr_i), .rxbuf_rd_i(rxbuf_rd_i),
    .flags_o(flags_o), .en_o(en_o), .irq_n_o(irq_n_o));

  task automatic compare(string req);
    vectors++;
    if (flags_o !== mf || en_o !== me || irq_n_o !== mirq) begin
      errors++;
      $display("FAIL %s: flags=%h en=%h irq_n=%b expected flags=%h en=%h irq_n=%b",
               req, flags_o, en_o, irq_n_o, mf, me, mirq);
    end
  endtask

  // drive one cycle at a falling edge, model the rising edge, compare at next falling edge
  task automatic step(input logic [N-1:0] ev, input logic fwe, input logic [N-1:0] fwd,
                      input logic ewe, input logic [N-1:0] ewd,
                      input logic tx, input logic rx, input string req);
    logic [N-1:0] clr;
    evt_i = ev; flag_we = fwe; flag_wdata = fwd; en_we = ewe; en_wdata = ewd;
    txbuf_wr_i = tx; rxbuf_rd_i = rx;
    @(posedge clk);
    mirq = !(|(mf & me));                       // R3: one clock of latency
    clr = ({N{fwe}} & ~fwd & W2C) | {tx, rx, 6'b0};  // R5/R6/R7
    mf = ev | (mf & ~clr);                      // R2/R8
    if (ewe) me = ewd;                          // R9
    @(negedge clk);
    evt_i = '0; flag_we = 1'b0; en_we = 1'b0; txbuf_wr_i = 1'b0; rxbuf_rd_i = 1'b0;
    compare(req);
  endtask

  task automatic idle(input string req);
    step('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, req);
  endtask

  task automatic clear_all();
    step('0, 1'b1, 8'h00, 1'b1, 8'h00, 1'b1, 1'b1, "R4");
    idle("R3");
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin : stim
    rst = 1'b1; evt_i = '0; flag_we = 0; flag_wdata = '0; en_we = 0; en_wdata = '0;
    txbuf_wr_i = 0; rxbuf_rd_i = 0;
    mf = '0; me = '0; mirq = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1");
    rst = 1'b0;
    idle("R1");

    // R10: each source alone lands on its own bit
    for (int b = 0; b < N; b++) begin
      step(8'(1 << b), 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R10");
      clear_all();
    end

    for (int p = 0; p < 256; p++) begin
      logic [N-1:0] e, w;
      e = 8'(p * 29 + 11) ^ 8'h5A;
      w = 8'(p * 37 + 3);
      // R2: set with enables at zero, line must stay high
      step(8'(p), 1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R2");
      idle("R2");
      // R9/R3: enable mask, flags untouched, line follows a cycle later
      step('0, 1'b0, '0, 1'b1, e, 1'b0, 1'b0, "R9");
      idle("R3");
      idle("R3");
      // R4/R5: flag write with mixed data
      step('0, 1'b1, w, 1'b0, '0, 1'b0, 1'b0, "R5");
      idle("R4");
      // R6 then R7
      step('0, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, "R6");
      step('0, 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, "R7");
      idle("R3");
      clear_all();
    end

    // R8: every set with every clear in the same cycle
    step(8'hFF, 1'b1, 8'h00, 1'b1, 8'hFF, 1'b1, 1'b1, "R8");
    idle("R8");
    step(8'h81, 1'b1, 8'h00, 1'b0, '0, 1'b1, 1'b1, "R8");
    idle("R8");
    // R9: lone enable write leaves flags
    step('0, 1'b0, '0, 1'b1, 8'h00, 1'b0, 1'b0, "R9");
    idle("R3");
    // R1: reset mid-run returns everything to the start state
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    mf = '0; me = '0; mirq = 1'b1;
    compare("R1");
    rst = 1'b0;
    idle("R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule